// File: doc/BRIEF.md
# Fault Coverage Campaign Engine

This block measures how well a set of pseudo-random test patterns exposes a list of injected faults in a small combinational circuit. The circuit copies and the fault injector sit outside. The block drives a 16-bit pattern bus and a fault index. It reads back two responses: one from a fault-free copy of the circuit and one from a copy that carries the selected fault.

After `start`, the engine first runs a capture pass. It applies the configured number of patterns and stores each fault-free response in an internal response memory. It then takes the faults one at a time and replays the same pattern sequence for each. Every faulty response is compared with the stored reference. A fault is marked detected at its first differing pattern, and the engine moves on to the next fault index at once. When the last fault is done, a bit-serial divider turns the detected count into an integer coverage percentage, and a one-cycle `done` pulse marks the result as valid.

Top module: `fault_cov_engine`

## Requirements
- R1: Patterns come from a 16-bit Fibonacci LFSR with taps 16, 14, 13 and 11. The next state is `{s[14:0], s[15]^s[13]^s[12]^s[10]}`. The state is set to the seed 16'hACE1 on an accepted start and again at the start of every fault, so each pass applies the same sequence beginning with the seed. The pattern bus is never zero while busy.
- R2: `goldResp` is sampled only during the capture pass, which covers the first `patCount` cycles after an accepted start (one pattern per cycle). Its value at any other time has no effect on any result.
- R3: A fault is detected exactly when, for at least one of the first `patCount` patterns, `faultResp` differs from the stored reference response for that pattern.
- R4: Per-fault duration is as follows. Let the first mismatch occur at pattern k (counted from 0). A detected fault then occupies k+2 cycles, and an undetected fault occupies `patCount`+1 cycles. Fault 0 begins right after the capture pass, and each later fault begins right after the previous one ends.
- R5: Each fault produces one single-cycle `faultRepValid` pulse, with `faultRepHit` and `faultRepIdx`. The pulses come in index order 0 to `faultTotal`-1. While busy, `faultSel` stays below the configured total.
- R6: At `done`, `detCount` equals the number of detected faults, with each fault counted once, and `faultsTotal` equals the configured total.
- R7: `coverage` equals floor(`detCount`×100/`faultsTotal`), and 100 when every fault is detected. `done` is a single-cycle pulse due FAULT_W+9 cycles after the last fault report, and the engine is idle when it rises.
- R8: `start` is ignored while busy. It is also ignored when `patCount` is 0, when `patCount` exceeds MAX_PATS, or when `faultTotal` is 0.
- R9: After reset, `busy`, `done`, `faultRepValid`, `coverage`, `detCount` and `faultsTotal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a campaign when idle |
| patCount | input | $clog2(MAX_PATS+1) | Patterns per pass, 1..MAX_PATS |
| faultTotal | input | FAULT_W | Number of faults to run, at least 1 |
| pattern | output | 16 | Test pattern to all circuit copies |
| faultSel | output | FAULT_W | Fault index for the injector |
| goldResp | input | RESP_W | Fault-free copy response |
| faultResp | input | RESP_W | Faulty copy response |
| busy | output | 1 | Campaign in progress |
| faultRepValid | output | 1 | Per-fault result pulse |
| faultRepHit | output | 1 | Reported fault was detected |
| faultRepIdx | output | FAULT_W | Index of the reported fault |
| detCount | output | FAULT_W | Detected fault count |
| faultsTotal | output | FAULT_W | Latched fault total |
| coverage | output | 7 | Coverage percent, 0..100 |
| done | output | 1 | Result valid pulse |

## Verification
The first per-fault report is due `patCount` plus that fault's duration cycles after the start edge. Each later report is due exactly that fault's duration (k+2, or `patCount`+1) after the previous one. The `done` pulse is due FAULT_W+9 cycles after the last report. The bench stamps every pulse with a cycle counter sampled on falling edges and compares each stamp with the stamps a reference model accumulates. During replay the bench drives an inverted reference response, so a design that reads `goldResp` live instead of its memory reports wrong hits.

// File: rtl/faultcov_pkg.sv
package faultcov_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic capWrite;
    logic issue;
    logic flush;
    logic rewind;
    logic faultEnd;
    logic nextFault;
    logic divStart;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic cfgOk;
    logic lastPat;
    logic lastFault;
    logic mismatch;
    logic divDone;
  } dpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAP, ST_RUN, ST_DRAIN, ST_DIVGO, ST_DIVWAIT
  } ctrlState_t;

  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/fc_divider.sv
module fc_divider #(
  parameter int NW = 13,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [NW-1:0] quotient,
  output logic          doneP
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem;
  logic [NW-1:0] quo;
  logic [CW-1:0] cnt;
  logic [DW:0]   remShift;
  logic [DW:0]   divExt;
  logic          fits;

  assign remShift = {rem, quo[NW-1]};
  assign divExt   = {1'b0, divisor};
  assign fits     = remShift >= divExt;
  assign quotient = quo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem   <= '0;
      quo   <= '0;
      cnt   <= '0;
      doneP <= 1'b0;
    end else begin
      doneP <= 1'b0;
      if (start) begin
        rem <= '0;
        quo <= dividend;
        cnt <= CW'(NW);
      end else if (cnt != '0) begin
        if (fits) begin
          rem <= DW'(remShift - divExt);
          quo <= {quo[NW-2:0], 1'b1};
        end else begin
          rem <= remShift[DW-1:0];
          quo <= {quo[NW-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) doneP <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import faultcov_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  ctrlState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start && status.cfgOk) begin
          strobe.loadCfg = 1'b1;
          stateNxt       = ST_CAP;
        end
      end
      ST_CAP: begin
        strobe.capWrite = 1'b1;
        if (status.lastPat) begin
          strobe.rewind = 1'b1;
          stateNxt      = ST_RUN;
        end
      end
      ST_RUN: begin
        if (status.mismatch) begin
          strobe.faultEnd = 1'b1;
          strobe.flush    = 1'b1;
          strobe.rewind   = 1'b1;
          if (status.lastFault) stateNxt = ST_DIVGO;
          else                  strobe.nextFault = 1'b1;
        end else begin
          strobe.issue = 1'b1;
          if (status.lastPat) stateNxt = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        strobe.faultEnd = 1'b1;
        strobe.flush    = 1'b1;
        strobe.rewind   = 1'b1;
        if (status.lastFault) begin
          stateNxt = ST_DIVGO;
        end else begin
          strobe.nextFault = 1'b1;
          stateNxt         = ST_RUN;
        end
      end
      ST_DIVGO: begin
        strobe.divStart = 1'b1;
        stateNxt        = ST_DIVWAIT;
      end
      ST_DIVWAIT: begin
        if (status.divDone) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/fc_datapath.sv
module fc_datapath
  import faultcov_pkg::*;
#(
  parameter int RESP_W   = 8,
  parameter int MAX_PATS = 64,
  parameter int FAULT_W  = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobe_t                    strobe,
  output dpStatus_t                      status,
  input  logic [$clog2(MAX_PATS+1)-1:0]  patCount,
  input  logic [FAULT_W-1:0]             faultTotal,
  input  logic [RESP_W-1:0]              goldResp,
  input  logic [RESP_W-1:0]              faultResp,
  output logic [LFSR_W-1:0]              pattern,
  output logic [FAULT_W-1:0]             faultSel,
  output logic                           faultRepValid,
  output logic                           faultRepHit,
  output logic [FAULT_W-1:0]             faultRepIdx,
  output logic [FAULT_W-1:0]             detCount,
  output logic [FAULT_W-1:0]             faultsTotal,
  output logic [6:0]                     coverage,
  output logic                           done
);
  localparam int PCW   = $clog2(MAX_PATS + 1);
  localparam int PAW   = (MAX_PATS > 1) ? $clog2(MAX_PATS) : 1;
  localparam int DVD_W = FAULT_W + 7;

  logic [LFSR_W-1:0]  lfsr;
  logic [PAW-1:0]     patIdx;
  logic [PCW-1:0]     nReg;
  logic [FAULT_W-1:0] fTotReg;
  logic [FAULT_W-1:0] detCnt;
  logic [RESP_W-1:0]  respMem [MAX_PATS];
  logic               s1Valid;
  logic [RESP_W-1:0]  s1Resp;
  logic [RESP_W-1:0]  s1Exp;
  logic [DVD_W-1:0]   dividend;
  logic [DVD_W-1:0]   quotient;
  logic               divDone;
  logic               stepPat;

  assign stepPat = strobe.capWrite | strobe.issue;

  assign status.cfgOk     = (patCount != '0) && (patCount <= PCW'(MAX_PATS)) &&
                            (faultTotal != '0);
  assign status.lastPat   = (PCW'(patIdx) == nReg - PCW'(1));
  assign status.lastFault = (faultSel == fTotReg - FAULT_W'(1));
  assign status.mismatch  = s1Valid && (s1Resp != s1Exp);
  assign status.divDone   = divDone;

  assign pattern     = lfsr;
  assign detCount    = detCnt;
  assign faultsTotal = fTotReg;

  // pattern source and index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr   <= LFSR_SEED;
      patIdx <= '0;
    end else if (strobe.loadCfg || strobe.rewind) begin
      lfsr   <= LFSR_SEED;
      patIdx <= '0;
    end else if (stepPat) begin
      lfsr   <= lfsrStep(lfsr);
      patIdx <= patIdx + PAW'(1);
    end
  end

  // reference response memory
  always_ff @(posedge clk) begin
    if (strobe.capWrite) respMem[patIdx] <= goldResp;
  end

  // compare stage: one cycle after the pattern is applied
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Resp  <= '0;
      s1Exp   <= '0;
    end else if (strobe.issue) begin
      s1Valid <= 1'b1;
      s1Resp  <= faultResp;
      s1Exp   <= respMem[patIdx];
    end else if (strobe.flush || strobe.loadCfg) begin
      s1Valid <= 1'b0;
    end
  end

  // configuration, fault walk and per-fault reports
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nReg          <= '0;
      fTotReg       <= '0;
      detCnt        <= '0;
      faultSel      <= '0;
      faultRepValid <= 1'b0;
      faultRepHit   <= 1'b0;
      faultRepIdx   <= '0;
    end else begin
      faultRepValid <= strobe.faultEnd;
      if (strobe.loadCfg) begin
        nReg     <= patCount;
        fTotReg  <= faultTotal;
        detCnt   <= '0;
        faultSel <= '0;
      end else begin
        if (strobe.faultEnd) begin
          faultRepHit <= status.mismatch;
          faultRepIdx <= faultSel;
          detCnt      <= detCnt + FAULT_W'(status.mismatch);
        end
        if (strobe.nextFault) faultSel <= faultSel + FAULT_W'(1);
      end
    end
  end

  assign dividend = DVD_W'(detCnt) * DVD_W'(100);

  fc_divider #(.NW(DVD_W), .DW(FAULT_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strobe.divStart),
    .dividend (dividend),
    .divisor  (fTotReg),
    .quotient (quotient),
    .doneP    (divDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coverage <= '0;
      done     <= 1'b0;
    end else begin
      done <= divDone;
      if (divDone) coverage <= quotient[6:0];
    end
  end
endmodule

// File: rtl/fault_cov_engine.sv
module fault_cov_engine
  import faultcov_pkg::*;
#(
  parameter int RESP_W   = 8,
  parameter int MAX_PATS = 64,
  parameter int FAULT_W  = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [$clog2(MAX_PATS+1)-1:0] patCount,
  input  logic [FAULT_W-1:0]            faultTotal,
  output logic [15:0]                   pattern,
  output logic [FAULT_W-1:0]            faultSel,
  input  logic [RESP_W-1:0]             goldResp,
  input  logic [RESP_W-1:0]             faultResp,
  output logic                          busy,
  output logic                          faultRepValid,
  output logic                          faultRepHit,
  output logic [FAULT_W-1:0]            faultRepIdx,
  output logic [FAULT_W-1:0]            detCount,
  output logic [FAULT_W-1:0]            faultsTotal,
  output logic [6:0]                    coverage,
  output logic                          done
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  fc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strobe (strobe),
    .busy   (busy)
  );

  fc_datapath #(
    .RESP_W(RESP_W), .MAX_PATS(MAX_PATS), .FAULT_W(FAULT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .status        (status),
    .patCount      (patCount),
    .faultTotal    (faultTotal),
    .goldResp      (goldResp),
    .faultResp     (faultResp),
    .pattern       (pattern),
    .faultSel      (faultSel),
    .faultRepValid (faultRepValid),
    .faultRepHit   (faultRepHit),
    .faultRepIdx   (faultRepIdx),
    .detCount      (detCount),
    .faultsTotal   (faultsTotal),
    .coverage      (coverage),
    .done          (done)
  );
endmodule

// File: rtl/fault_cov_engine_chk.sv
module fault_cov_engine_chk #(
  parameter int MAX_PATS = 64,
  parameter int FAULT_W  = 6
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          start,
  input logic [$clog2(MAX_PATS+1)-1:0] patCount,
  input logic [FAULT_W-1:0]            faultTotal,
  input logic [15:0]                   pattern,
  input logic [FAULT_W-1:0]            faultSel,
  input logic                          busy,
  input logic                          faultRepValid,
  input logic [FAULT_W-1:0]            detCount,
  input logic [FAULT_W-1:0]            faultsTotal,
  input logic [6:0]                    coverage,
  input logic                          done
);
  p_seed_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> pattern == 16'hACE1);
  p_nonzero_r1: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> pattern != 16'h0000);
  p_rep_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    faultRepValid |=> !faultRepValid);
  p_sel_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> faultSel < faultsTotal);
  p_rep_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    faultRepValid |-> busy);
  p_det_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> detCount <= faultsTotal);
  p_single_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_cov_max_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> coverage <= 7'd100);
  p_full_cov_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && detCount == faultsTotal) |-> coverage == 7'd100);
  p_idle_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (patCount == '0 || faultTotal == '0)) |=> !busy);
endmodule

bind fault_cov_engine fault_cov_engine_chk #(
  .MAX_PATS(MAX_PATS), .FAULT_W(FAULT_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .start         (start),
  .patCount      (patCount),
  .faultTotal    (faultTotal),
  .pattern       (pattern),
  .faultSel      (faultSel),
  .busy          (busy),
  .faultRepValid (faultRepValid),
  .detCount      (detCount),
  .faultsTotal   (faultsTotal),
  .coverage      (coverage),
  .done          (done)
);

// File: tb/tb_fault_cov_engine.sv
`timescale 1ns/1ps
module tb_fault_cov_engine;
  localparam int RESPW = 8;
  localparam int MAXP  = 64;
  localparam int FW    = 6;
  localparam int PCW   = $clog2(MAXP + 1);
  localparam int NWDIV = FW + 7;
  localparam logic [15:0] SEED = 16'hACE1;

  // stimulus table: patterns, faults, mid-run start poke
  localparam int NVEC = 6;
  localparam int VECS [NVEC][3] = '{
    '{8, 8, 0}, '{1, 5, 0}, '{64, 12, 1}, '{3, 1, 0}, '{20, 40, 0}, '{2, 63, 0}
  };

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic [PCW-1:0] patCount = '0;
  logic [FW-1:0] faultTotal = '0;
  logic [15:0] pattern;
  logic [FW-1:0] faultSel;
  logic [RESPW-1:0] goldResp, faultResp;
  logic busy, faultRepValid, faultRepHit, done;
  logic [FW-1:0] faultRepIdx, detCount, faultsTotal;
  logic [6:0] coverage;
  logic corrupt = 0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int repCnt = 0;
  int repStamp [64];
  int repHitA [64];
  int repIdxA [64];
  bit doneSeen = 0;
  int doneStamp, doneCov, doneDet, doneTot;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] nextPat(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [7:0] goldFn(input logic [15:0] p);
    return (p[7:0] ^ p[15:8]) + 8'd3;
  endfunction

  function automatic logic [7:0] faultyFn(input logic [15:0] p, input int idx);
    logic [7:0] g;
    g = goldFn(p);
    case (idx % 8)
      0: return g ^ 8'h01;
      1: return g | 8'h04;
      2: return g & 8'hBF;
      3: return g;
      4: return (p[3:0] == 4'hF) ? (g ^ 8'h80) : g;
      5: return (p[7:0] == 8'h00) ? (g ^ 8'h01) : g;
      6: return g ^ {7'b0, p[15] & p[0]};
      default: return g;
    endcase
  endfunction

  assign goldResp  = corrupt ? ~goldFn(pattern) : goldFn(pattern);
  assign faultResp = faultyFn(pattern, int'(faultSel));

  fault_cov_engine #(.RESP_W(RESPW), .MAX_PATS(MAXP), .FAULT_W(FW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .patCount(patCount),
    .faultTotal(faultTotal), .pattern(pattern), .faultSel(faultSel),
    .goldResp(goldResp), .faultResp(faultResp), .busy(busy),
    .faultRepValid(faultRepValid), .faultRepHit(faultRepHit),
    .faultRepIdx(faultRepIdx), .detCount(detCount),
    .faultsTotal(faultsTotal), .coverage(coverage), .done(done)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (faultRepValid) begin
        if (repCnt < 64) begin
          repStamp[repCnt] = cyc;
          repHitA[repCnt]  = int'(faultRepHit);
          repIdxA[repCnt]  = int'(faultRepIdx);
        end
        repCnt = repCnt + 1;
      end
      if (done) begin
        doneSeen  = 1;
        doneStamp = cyc;
        doneCov   = int'(coverage);
        doneDet   = int'(detCount);
        doneTot   = int'(faultsTotal);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCampaign(input int n, input int f, input int poke);
    int s;
    int t;
    int det;
    int patBad;
    logic [15:0] p;
    repCnt = 0;
    doneSeen = 0;
    corrupt = 0;
    @(negedge clk);
    patCount = PCW'(n);
    faultTotal = FW'(f);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    s = cyc;
    // R1: capture pass sequence, then replay from the seed
    p = SEED;
    patBad = (pattern != p) ? 1 : 0;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      p = (j == n) ? SEED : nextPat(p);
      if (pattern != p) patBad++;
    end
    chk(patBad == 0, "R1 pattern sequence mismatches", patBad, 0);
    // R2: reference input ignored from here on
    corrupt = 1;
    if (poke != 0) begin
      start = 1;
      patCount = PCW'(3);
      faultTotal = FW'(1);
      @(negedge clk);
      start = 0;
      patCount = PCW'(n);
      faultTotal = FW'(f);
    end
    for (int g = 0; g < 20000 && !doneSeen; g++) @(negedge clk);
    chk(doneSeen == 1, "R7 done seen", int'(doneSeen), 1);
    chk(repCnt == f, "R5 report count", repCnt, f);
    t = s + n;
    det = 0;
    for (int fi = 0; fi < f; fi++) begin
      int k;
      int cost;
      k = -1;
      p = SEED;
      for (int j = 0; j < n; j++) begin
        if (k < 0 && faultyFn(p, fi) != goldFn(p)) k = j;
        p = nextPat(p);
      end
      cost = (k >= 0) ? k + 2 : n + 1;
      t = t + cost;
      if (k >= 0) det++;
      if (fi < repCnt) begin
        chk(repHitA[fi] == ((k >= 0) ? 1 : 0), "R3 fault hit", repHitA[fi], (k >= 0) ? 1 : 0);
        chk(repIdxA[fi] == fi, "R5 report order", repIdxA[fi], fi);
        chk(repStamp[fi] == t, "R4 report cycle", repStamp[fi], t);
      end
    end
    chk(doneStamp == t + NWDIV + 2, "R7 done cycle", doneStamp, t + NWDIV + 2);
    chk(doneDet == det, "R6 detected count", doneDet, det);
    chk(doneTot == f, "R6 total count", doneTot, f);
    chk(doneCov == (det * 100) / f, "R7 coverage", doneCov, (det * 100) / f);
    @(negedge clk);
    chk(busy == 0, "R7 idle after done", int'(busy), 0);
    corrupt = 0;
  endtask

  task automatic tryBadStart(input int n, input int f, input string tag);
    @(negedge clk);
    patCount = PCW'(n);
    faultTotal = FW'(f);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0, tag, int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9: reset state
    chk(busy == 0, "R9 busy", int'(busy), 0);
    chk(done == 0, "R9 done", int'(done), 0);
    chk(faultRepValid == 0, "R9 report", int'(faultRepValid), 0);
    chk(coverage == 0, "R9 coverage", int'(coverage), 0);
    chk(detCount == 0 && faultsTotal == 0, "R9 counts", int'(detCount), 0);
    // R8: rejected configurations
    tryBadStart(0, 4, "R8 zero patterns");
    tryBadStart(MAXP + 1, 4, "R8 too many patterns");
    tryBadStart(5, 0, "R8 zero faults");
    // table walk (R1..R7, poke covers R8 while busy)
    for (int v = 0; v < NVEC; v++) runCampaign(VECS[v][0], VECS[v][1], VECS[v][2]);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule